// File: doc/BRIEF.md
# Power-of-Two Rounding Approximate Multiplier

This block multiplies two N-bit operands approximately. It first rounds each operand magnitude to the nearest power of two. It then forms the product from three shifted terms, one adder and a reduced subtractor, so no partial-product array is needed. The dropped cross term makes the result slightly high or slightly low. The result is exact whenever either operand magnitude is a power of two. The worst relative error, about 11.1 %, occurs when both magnitudes have the form 3·2^k.

A two-bit mode input selects how the operands are read. In unsigned mode the operands are plain magnitudes. In signed-exact mode the magnitudes are found by two's complement negation, and the result is negated the same way. Signed-approximate mode uses bit inversion alone for both steps. This trades a small extra error for a shorter negation path. Each `valid_in` pulse loads one result into the output register, and `valid_out` marks it on the following cycle.

Top module: `rmul_top`

## Requirements
- R1: With magnitudes A, B and rounded values Ar, Br, the result magnitude equals Ar·B + Br·A − Ar·Br (for example, unsigned 11 × 13 gives 152).
- R2: A nonzero magnitude rounds to the nearest power of two. A value midway between two powers (3·2^k, k ≥ 1) rounds to the larger one. The value 3 rounds to 2.
- R3: A zero magnitude rounds to zero, and any product with a zero magnitude operand has magnitude zero.
- R4: Mode codes 2'b00 and 2'b11 are unsigned. Operands are taken as magnitudes, and a value whose two top bits are both one rounds to 2^N (unsigned 255 × 255 gives 65024 for N = 8).
- R5: Mode 2'b01 is signed-exact. The operand MSB is the sign, and magnitudes are two's complement negations, so −2^(N−1) has magnitude 2^(N−1). The result is the two's complement negation of the magnitude result when exactly one operand is negative.
- R6: Mode 2'b10 is signed-approximate. Negative operands and negative results are negated by bit inversion only, with no +1 (−1 × 100 gives all ones).
- R7: The subtraction of the power-of-two term Ar·Br is exact for every sum it can receive.
- R8: When either operand magnitude is a power of two, the result magnitude equals the exact product of the magnitudes.
- R9: For both operands equal to 12 in unsigned mode, the result is 128 (exact 144).
- R10: `valid_out` is high in the cycle after a cycle with `valid_in` high and low otherwise. `product` changes only on a clock edge where `valid_in` is high.
- R11: While `rst_n` is low, `valid_out` and `product` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 00/11 unsigned, 01 signed-exact, 10 signed-approximate |
| valid_in | input | 1 | Operands are valid; load the result |
| op_a | input | N | Operand A |
| op_b | input | N | Operand B |
| valid_out | output | 1 | Result in `product` is new this cycle |
| product | output | 2N | Registered approximate product |

## Verification
On every cycle, the assertions check that each rounding output has at most one bit set and lies in the nearest-power bracket. They also check that zero maps to zero, that the reduced subtractor agrees with true subtraction, and that a power-of-two magnitude gives the exact product. They further check that a signed-exact result with one negative operand comes out negative, and that the valid strobe and the output hold follow the one-cycle load rule. The exact numeric results for tie values, the value 3, the top-bit rounding in unsigned mode, −2^(N−1), and the inversion-only negation can only be shown by the bench. The bench drives chosen operand pairs and compares them with an independent arithmetic model of the same approximation.

// File: rtl/rmul_pkg.sv
package rmul_pkg;
  typedef enum logic [1:0] {
    RM_UNS     = 2'b00,
    RM_SEXACT  = 2'b01,
    RM_SAPPROX = 2'b10,
    RM_UNS_ALT = 2'b11
  } rm_mode_e;
endpackage

// File: rtl/rmul_negate.sv
// Conditional negation: exact two's complement or inversion only.
module rmul_negate #(
  parameter int W = 8
) (
  input  logic [W-1:0] din,
  input  logic         neg,
  input  logic         approx,
  output logic [W-1:0] dout
);
  always_comb begin
    if (!neg)        dout = din;
    else if (approx) dout = ~din;
    else             dout = ~din + W'(1);
  end
endmodule

// File: rtl/rmul_round.sv
// Rounds a magnitude to the nearest power of two (one-hot, N+1 bits) and
// encodes the set position as a shift amount.
module rmul_round #(
  parameter int N  = 8,
  parameter int SW = $clog2(N + 1)
) (
  input  logic [N-1:0]  mag,
  output logic [N:0]    rnd,
  output logic [SW-1:0] shamt
);
  logic [N+2:0] pad;
  assign pad = {1'b0, mag, 2'b00};

  always_comb begin
    logic seen, cur, p1, p2, c1, c2;
    seen = 1'b0;
    rnd  = '0;
    for (int i = N; i >= 0; i--) begin
      cur = pad[i+2];
      p1  = pad[i+1];
      p2  = pad[i];
      c1  = cur & ~p1;
      c2  = (i >= 3) & ~cur & p1 & p2;
      if (i == 1) c1 = cur;
      rnd[i] = ~seen & (c1 | c2);
      seen   = seen | cur;
    end
  end

  always_comb begin
    shamt = '0;
    for (int i = 0; i <= N; i++) begin
      if (rnd[i]) shamt = SW'(i);
    end
  end

  always_comb begin
    int mi, ri;
    mi = int'(mag);
    ri = int'(rnd);
    assert_round_onehot_R2: assert ($onehot0(rnd));
    assert_zero_rounds_zero_R3: assert ((mi == 0) == (ri == 0));
    assert_round_bracket_R2: assert (ri == 0 || (4 * mi >= 3 * ri && (2 * mi < 3 * ri || mi == 3)));
  end
endmodule

// File: rtl/rmul_shift.sv
// Logarithmic barrel shifter with a zeroing enable.
module rmul_shift #(
  parameter int IW = 8,
  parameter int OW = 17,
  parameter int SW = 4
) (
  input  logic [IW-1:0] din,
  input  logic [SW-1:0] amt,
  input  logic          en,
  output logic [OW-1:0] dout
);
  logic [OW-1:0] stage [SW+1];

  assign stage[0] = {{(OW-IW){1'b0}}, din};

  for (genvar s = 0; s < SW; s++) begin : g_stage
    assign stage[s+1] = amt[s] ? (stage[s] << (1 << s)) : stage[s];
  end

  assign dout = en ? stage[SW] : '0;
endmodule

// File: rtl/rmul_pow2sub.sv
// Subtracts a value with at most one bit set: bits below it pass, a borrow
// mask runs upward from it across zeros of the minuend.
module rmul_pow2sub #(
  parameter int W  = 17,
  parameter int OW = 16
) (
  input  logic [W-1:0]  minu,
  input  logic [W-1:0]  pow2,
  output logic [OW-1:0] dout
);
  logic [W-1:0] mask;
  logic [W-1:0] diff;

  always_comb begin
    logic run;
    run = 1'b0;
    for (int i = 0; i < W; i++) begin
      run     = run | pow2[i];
      mask[i] = run;
      run     = run & ~minu[i];
    end
  end

  assign diff = minu ^ mask;
  assign dout = diff[OW-1:0];

  always_comb begin
    if ($onehot0(pow2) && minu >= pow2)
      assert_sub_exact_R7: assert (diff + pow2 == minu);
  end
endmodule

// File: rtl/rmul_top.sv
module rmul_top #(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [1:0]     mode,
  input  logic           valid_in,
  input  logic [N-1:0]   op_a,
  input  logic [N-1:0]   op_b,
  output logic           valid_out,
  output logic [2*N-1:0] product
);
  import rmul_pkg::*;

  localparam int PW = 2 * N;
  localparam int IW = 2 * N + 1;
  localparam int SW = $clog2(N + 1);

  rm_mode_e mode_e;
  logic is_signed, is_approx;
  logic sgn_a, sgn_b, res_neg;
  logic [N-1:0]  mag_a, mag_b;
  logic [N:0]    rnd_a, rnd_b;
  logic [SW-1:0] sh_a, sh_b;
  logic nz_a, nz_b;
  logic [IW-1:0] t_ab, t_ba, t_rr, psum;
  logic [PW-1:0] res_mag, prod_next;
  logic          valid_d, valid_q;
  logic [PW-1:0] prod_d, prod_q;

  assign mode_e    = rm_mode_e'(mode);
  assign is_signed = (mode_e == RM_SEXACT) || (mode_e == RM_SAPPROX);
  assign is_approx = (mode_e == RM_SAPPROX);
  assign sgn_a     = is_signed & op_a[N-1];
  assign sgn_b     = is_signed & op_b[N-1];
  assign res_neg   = sgn_a ^ sgn_b;

  rmul_negate #(.W(N)) u_abs_a (.din(op_a), .neg(sgn_a), .approx(is_approx), .dout(mag_a));
  rmul_negate #(.W(N)) u_abs_b (.din(op_b), .neg(sgn_b), .approx(is_approx), .dout(mag_b));

  rmul_round #(.N(N), .SW(SW)) u_rnd_a (.mag(mag_a), .rnd(rnd_a), .shamt(sh_a));
  rmul_round #(.N(N), .SW(SW)) u_rnd_b (.mag(mag_b), .rnd(rnd_b), .shamt(sh_b));

  assign nz_a = |rnd_a;
  assign nz_b = |rnd_b;

  // Ar*B, Br*A and Ar*Br as shifts
  rmul_shift #(.IW(N),   .OW(IW), .SW(SW)) u_sh_ab (.din(mag_b), .amt(sh_a), .en(nz_a), .dout(t_ab));
  rmul_shift #(.IW(N),   .OW(IW), .SW(SW)) u_sh_ba (.din(mag_a), .amt(sh_b), .en(nz_b), .dout(t_ba));
  rmul_shift #(.IW(N+1), .OW(IW), .SW(SW)) u_sh_rr (.din(rnd_a), .amt(sh_b), .en(nz_b), .dout(t_rr));

  assign psum = t_ab + t_ba;

  rmul_pow2sub #(.W(IW), .OW(PW)) u_sub (.minu(psum), .pow2(t_rr), .dout(res_mag));

  rmul_negate #(.W(PW)) u_sign (.din(res_mag), .neg(res_neg), .approx(is_approx), .dout(prod_next));

  // next state
  always_comb begin
    valid_d = valid_in;
    prod_d  = prod_q;
    if (valid_in) prod_d = prod_next;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      prod_q  <= '0;
    end else begin
      valid_q <= valid_d;
      prod_q  <= prod_d;
    end
  end

  assign valid_out = valid_q;
  assign product   = prod_q;

  always_comb begin
    if (mag_a != '0 && (mag_a & (mag_a - N'(1))) == '0)
      assert_pow2_exact_R8: assert (res_mag == PW'(mag_a) * PW'(mag_b));
  end

  assert_valid_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    valid_in |=> valid_out);
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_in |=> (!valid_out && $stable(product)));
  assert_sign_neg_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && mode_e == RM_SEXACT && res_neg && res_mag != '0) |=> product[PW-1]);
  assert_reset_zero_R11: assert property (@(posedge clk)
    !rst_n |-> (!valid_out && product == '0));
endmodule

// File: tb/sim_rmul_top.sv
module sim_rmul_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic clk, rst_n, valid_in, valid_out;
  logic [1:0] mode;
  logic [N-1:0] op_a, op_b;
  logic [2*N-1:0] product;

  int n_checks = 0;
  int n_fail = 0;

  rmul_top #(.N(N)) u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode), .valid_in(valid_in),
    .op_a(op_a), .op_b(op_b), .valid_out(valid_out), .product(product)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // {mode, a, b, expected}
  localparam logic [33:0] VEC [15] = '{
    {2'd0, 8'd12,  8'd12,  16'h0080},  // R9 worst case
    {2'd0, 8'd3,   8'd3,   16'h0008},  // R2 three rounds to two
    {2'd0, 8'd6,   8'd5,   16'h0020},  // R2 tie rounds up
    {2'd0, 8'd16,  8'd200, 16'h0C80},  // R8 power-of-two operand
    {2'd0, 8'd255, 8'd255, 16'hFE00},  // R4 top-bit rounding
    {2'd0, 8'd0,   8'd77,  16'h0000},  // R3 zero operand
    {2'd1, 8'hFD,  8'd5,   16'hFFF2},  // R5 -3 x 5
    {2'd1, 8'h80,  8'h80,  16'h4000},  // R5 most negative
    {2'd1, 8'hF4,  8'hF4,  16'h0080},  // R5 -12 x -12
    {2'd2, 8'hFD,  8'd5,   16'hFFF5},  // R6 inversion only
    {2'd2, 8'hFF,  8'd100, 16'hFFFF},  // R6 minus one
    {2'd2, 8'd7,   8'd9,   16'h0040},  // R6 positive operands
    {2'd3, 8'd255, 8'd255, 16'hFE00},  // R4 alternate unsigned code
    {2'd1, 8'd100, 8'hC0,  16'hE700},  // R8 signed power of two
    {2'd0, 8'd11,  8'd13,  16'h0098}   // R1 R7 general case
  };

  function automatic int round_p2(int m);
    int lo;
    if (m == 0) return 0;
    if (m == 3) return 2;
    lo = 1;
    while (lo * 2 <= m) lo = lo * 2;
    if (m - lo < 2 * lo - m) return lo;
    return 2 * lo;
  endfunction

  function automatic logic [15:0] ref_prod(int md, logic [7:0] a, logic [7:0] b);
    bit sg, ap, sa, sb;
    int ma, mb, ra, rb, r;
    sg = (md == 1) || (md == 2);
    ap = (md == 2);
    sa = sg && a[7];
    sb = sg && b[7];
    ma = int'(a);
    mb = int'(b);
    if (sa) ma = ap ? 255 - ma : 256 - ma;
    if (sb) mb = ap ? 255 - mb : 256 - mb;
    ra = round_p2(ma);
    rb = round_p2(mb);
    r = ra * mb + rb * ma - ra * rb;
    if (sa != sb) r = ap ? -r - 1 : -r;
    return r[15:0];
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic apply(logic [1:0] md, logic [7:0] a, logic [7:0] b);
    @(negedge clk);
    mode = md; op_a = a; op_b = b; valid_in = 1'b1;
    @(negedge clk);
    valid_in = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; valid_in = 1'b0; mode = 2'd0; op_a = '0; op_b = '0;
    repeat (3) @(negedge clk);
    check("R11 reset valid_out", 32'(valid_out), 32'd0);
    check("R11 reset product", 32'(product), 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < 15; i++) begin
      apply(VEC[i][33:32], VEC[i][31:24], VEC[i][23:16]);
      check("R10 valid_out after load", 32'(valid_out), 32'd1);
      check("R1 R7 table vector", 32'(product), 32'(VEC[i][15:0]));
    end

    // R10: idle cycles keep result and drop the strobe
    apply(2'd0, 8'd11, 8'd13);
    mode = 2'd1; op_a = 8'd200; op_b = 8'd3;
    @(negedge clk);
    check("R10 valid_out idle", 32'(valid_out), 32'd0);
    @(negedge clk);
    check("R10 product held", 32'(product), 32'h0098);

    // R1 sweep against the arithmetic model in all modes
    for (int md = 0; md < 4; md++) begin
      for (int a = 0; a < 256; a += 37) begin
        for (int b = 1; b < 256; b += 29) begin
          apply(md[1:0], a[7:0], b[7:0]);
          check("R1 sweep", 32'(product), 32'(ref_prod(md, a[7:0], b[7:0])));
        end
      end
    end

    // R3 zero in signed-exact mode
    apply(2'd1, 8'hC8, 8'd0);
    check("R3 zero signed", 32'(product), 32'd0);

    // R11 asynchronous reset mid-run
    apply(2'd0, 8'd200, 8'd200);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R11 async reset product", 32'(product), 32'd0);
    check("R11 async reset valid_out", 32'(valid_out), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule